// File: doc/BRIEF.md
# Six-Switch Driver Fault Latch and Status Word

This block holds the protection state of a six-switch power output stage: three low-side and three high-side switches. It filters a raw supply-undervoltage flag and per-switch overcurrent flags with cycle-count delay filters. Overtemperature flags take effect on the next clock edge. Every resulting fault is latched until a status-reset command clears it.

From that state it drives two sets of outputs. The first is a per-switch disable mask and a global output-off signal, which the output stage combines with its own on-commands. The second is a 16-bit status word that is returned to the host through the serial link.

The command decoder feeds the block with the decoded control bits of the current command word. These are a one-cycle status-reset pulse, the overcurrent-shutdown enable, the open-load diagnosis enable, the run/standby bit and the six on-bits. The analog sense front end supplies the comparator flags.

Top module: `drv_fault_status`

## Requirements
- R1: After a synchronous active-low reset, with all sense flags low, run high and no switch on, the status word is 0x0000, the fault mask is 0 and output-off is low.
- R2: Status bit 0 follows the thermal prewarning input live, with no latching. Bits 7 to 12 always read 0. Bit 14 reads high whenever the run bit is low.
- R3: With open-load diagnosis disabled, status bit i+1 (i = 0..5, in the order LS1, HS1, LS2, HS2, LS3, HS3) is high when on-bit i is high, switch i is not fault-disabled and output-off is low.
- R4: With open-load diagnosis enabled, status bit i+1 equals open-load flag i, and a status-reset pulse does not change it.
- R5: Output-off and status bit 15 go high in the UV_DLY-th consecutive cycle in which the undervoltage flag is high. A shorter pulse has no effect, and any drop of the flag restarts the count.
- R6: When the undervoltage flag drops, output-off falls in the same cycle. Status bit 15 stays high until a status-reset pulse, provided the flag was high across at least one clock edge after qualifying.
- R7: An overtemperature flag on switch i sets fault-mask bit i and status bit 13 one clock edge later. From then on, status bit i+1 reads 0.
- R8: A status-reset pulse does not clear the fault of a switch whose overtemperature flag is still high. Once the flag is low, the next status-reset pulse clears it.
- R9: With overcurrent shutdown enabled, an overcurrent flag held for OC_DLY consecutive cycles sets fault-mask bit i and status bit 13 at the OC_DLY-th edge. A shorter pulse has no effect.
- R10: With overcurrent shutdown disabled, an overcurrent flag of any length sets neither the fault mask nor status bit 13.
- R11: A status-reset pulse, when no fault flag is active, clears status bits 13 and 15 and the whole fault mask at the next edge.
- R12: With the run bit low, output-off is high, every per-switch status bit reads 0 in normal mode, and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srr_i | input | 1 | Status-reset pulse, one cycle per executed command |
| ocs_en_i | input | 1 | Overcurrent shutdown enable |
| old_en_i | input | 1 | Open-load diagnosis enable (high = enabled) |
| sw_run_i | input | 1 | Run bit; low selects standby |
| sw_on_i | input | 6 | On-bits, index 0..5 = LS1, HS1, LS2, HS2, LS3, HS3 |
| oc_raw_i | input | 6 | Per-switch overcurrent comparator flags |
| ot_raw_i | input | 6 | Per-switch overtemperature flags |
| openload_i | input | 6 | Per-switch open-load comparator flags |
| prewarn_i | input | 1 | Thermal prewarning flag |
| uv_raw_i | input | 1 | Raw supply-undervoltage flag |
| fault_dis_o | output | 6 | Per-switch fault-disable mask |
| all_off_o | output | 1 | Global output disable (undervoltage or standby) |
| status_o | output | 16 | Status word |

## Verification
The status word and output-off are combinational from registered state. Live fields (prewarning, open-load, on-bits, standby, undervoltage release) are therefore sampled a nanosecond after the input is driven at a falling clock edge, before any rising edge. Latched results (fault mask, overload, supply-fail set and clear) are sampled at the falling edge that follows the rising edge that latches them. For overtemperature and status-reset that is one edge later. For overcurrent it is OC_DLY edges after the flag rises, and undervoltage qualification shows after UV_DLY-1 edges. Each filter is also checked one edge short of its limit, so an off-by-one in either direction is reported.

// File: rtl/drvf_pkg.sv
`timescale 1ns/1ps
// Shared constants for the driver fault/status logic.
// Assumes six switches and a 16-bit status word; bit positions are fixed
// because the host software decodes them.
package drvf_pkg;
    localparam int NSW        = 6;
    localparam int STAT_W     = 16;
    localparam int ST_PREWARN = 0;
    localparam int ST_SW_LSB  = 1;
    localparam int ST_OVL     = 13;
    localparam int ST_INH     = 14;
    localparam int ST_PSF     = 15;
    typedef logic [NSW-1:0] sw_vec_t;
endpackage

// File: rtl/drvf_delay_filter.sv
`timescale 1ns/1ps
// Persistence filter: held_o is high in the DLY-th consecutive cycle that
// raw_i is high and stays high while raw_i does. Any low cycle restarts it.
// Assumes DLY >= 1.
module drvf_delay_filter #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic held_o
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive high cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!raw_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign held_o = raw_i && (cnt_q == LAST);
endmodule

// File: rtl/drvf_switch_guard.sv
`timescale 1ns/1ps
// Protection latch for one switch. Overtemperature trips at once;
// overcurrent trips after the shutdown filter when enabled.
// A status-reset clears the latch only while no trip is active.
module drvf_switch_guard #(
    parameter int OC_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw_i,
    input  logic ocs_en_i,
    input  logic ot_raw_i,
    input  logic clr_i,
    output logic trip_o,
    output logic fault_o
);
    logic oc_held;
    logic fault_q;

    drvf_delay_filter #(.DLY(OC_DLY)) u_oc_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (oc_raw_i && ocs_en_i),
        .held_o (oc_held)
    );

    assign trip_o = ot_raw_i || oc_held;

    // Latch the fault; set wins over a concurrent clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= trip_o || (fault_q && !clr_i);
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/drvf_supply_guard.sv
`timescale 1ns/1ps
// Supply monitor: filters the undervoltage flag, reports it live as a
// global disable and keeps a sticky supply-fail flag until cleared.
module drvf_supply_guard #(
    parameter int UV_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_raw_i,
    input  logic clr_i,
    output logic uv_held_o,
    output logic psf_o
);
    logic uv_held;
    logic psf_q;

    drvf_delay_filter #(.DLY(UV_DLY)) u_uv_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (uv_raw_i),
        .held_o (uv_held)
    );

    // Sticky supply-fail; a qualified undervoltage outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psf_q <= 1'b0;
        end else begin
            psf_q <= uv_held || (psf_q && !clr_i);
        end
    end

    assign uv_held_o = uv_held;
    assign psf_o     = psf_q || uv_held;
endmodule

// File: rtl/drvf_status_pack.sv
`timescale 1ns/1ps
// Builds the status word from live flags and latched state.
// Purely combinational; unused positions read zero.
module drvf_status_pack
    import drvf_pkg::*;
(
    input  sw_vec_t             sw_on_i,
    input  sw_vec_t             fault_i,
    input  sw_vec_t             openload_i,
    input  logic                all_off_i,
    input  logic                old_en_i,
    input  logic                prewarn_i,
    input  logic                standby_i,
    input  logic                ovl_i,
    input  logic                psf_i,
    output logic [STAT_W-1:0]   status_o
);
    sw_vec_t sw_bits;

    // Per-switch field: open-load result or effective on-state.
    always_comb begin
        for (int i = 0; i < NSW; i++) begin
            if (old_en_i) begin
                sw_bits[i] = openload_i[i];
            end else begin
                sw_bits[i] = sw_on_i[i] && !fault_i[i] && !all_off_i;
            end
        end
    end

    // Place every field at its fixed position.
    always_comb begin
        status_o = '0;
        status_o[ST_PREWARN]             = prewarn_i;
        status_o[ST_SW_LSB +: NSW]       = sw_bits;
        status_o[ST_OVL]                 = ovl_i;
        status_o[ST_INH]                 = standby_i;
        status_o[ST_PSF]                 = psf_i;
    end
endmodule

// File: rtl/drv_fault_status.sv
`timescale 1ns/1ps
// Top of the driver fault/status logic: one guard per switch, a supply
// guard, the overload latch and the status packer.
// Assumes srr_i is a single-cycle pulse per executed command and that all
// sense flags are already synchronous to clk.
module drv_fault_status
    import drvf_pkg::*;
#(
    parameter int UV_DLY = 8,
    parameter int OC_DLY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srr_i,
    input  logic               ocs_en_i,
    input  logic               old_en_i,
    input  logic               sw_run_i,
    input  logic [NSW-1:0]     sw_on_i,
    input  logic [NSW-1:0]     oc_raw_i,
    input  logic [NSW-1:0]     ot_raw_i,
    input  logic [NSW-1:0]     openload_i,
    input  logic               prewarn_i,
    input  logic               uv_raw_i,
    output logic [NSW-1:0]     fault_dis_o,
    output logic               all_off_o,
    output logic [STAT_W-1:0]  status_o
);
    sw_vec_t trip;
    sw_vec_t fault;
    logic    uv_held;
    logic    psf;
    logic    ovl_q;

    for (genvar g = 0; g < NSW; g++) begin : g_sw
        drvf_switch_guard #(.OC_DLY(OC_DLY)) u_guard (
            .clk      (clk),
            .rst_n    (rst_n),
            .oc_raw_i (oc_raw_i[g]),
            .ocs_en_i (ocs_en_i),
            .ot_raw_i (ot_raw_i[g]),
            .clr_i    (srr_i),
            .trip_o   (trip[g]),
            .fault_o  (fault[g])
        );
    end

    drvf_supply_guard #(.UV_DLY(UV_DLY)) u_supply (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_raw_i  (uv_raw_i),
        .clr_i     (srr_i),
        .uv_held_o (uv_held),
        .psf_o     (psf)
    );

    // Overload flag: set by any switch trip, cleared by status-reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_q <= 1'b0;
        end else begin
            ovl_q <= (|trip) || (ovl_q && !srr_i);
        end
    end

    assign all_off_o   = uv_held || !sw_run_i;
    assign fault_dis_o = fault;

    drvf_status_pack u_pack (
        .sw_on_i    (sw_on_i),
        .fault_i    (fault),
        .openload_i (openload_i),
        .all_off_i  (all_off_o),
        .old_en_i   (old_en_i),
        .prewarn_i  (prewarn_i),
        .standby_i  (!sw_run_i),
        .ovl_i      (ovl_q),
        .psf_i      (psf),
        .status_o   (status_o)
    );
endmodule

// File: rtl/drv_fault_status_chk.sv
`timescale 1ns/1ps
// Property checker for drv_fault_status, attached by bind below.
module drv_fault_status_chk
    import drvf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srr_i,
    input  logic               ocs_en_i,
    input  logic               old_en_i,
    input  logic               sw_run_i,
    input  logic [NSW-1:0]     oc_raw_i,
    input  logic [NSW-1:0]     ot_raw_i,
    input  logic [NSW-1:0]     fault_dis_o,
    input  logic               all_off_o,
    input  logic [STAT_W-1:0]  status_o
);
    AST_PSF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_PSF] && !srr_i) |=> status_o[ST_PSF]);  // R6

    AST_OT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_raw_i != '0) |=> ((fault_dis_o & $past(ot_raw_i)) == $past(ot_raw_i)));  // R7

    AST_SRR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (srr_i && ot_raw_i == '0 && oc_raw_i == '0) |=> (!status_o[ST_OVL] && fault_dis_o == '0));  // R11

    AST_NO_OVL_WITHOUT_OCS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ocs_en_i && ot_raw_i == '0) |=> !$rose(status_o[ST_OVL]));  // R10

    AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_run_i |-> (all_off_o && status_o[ST_INH]));  // R12

    AST_DISABLED_READS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !old_en_i |-> ((status_o[ST_SW_LSB +: NSW] & fault_dis_o) == '0));  // R7
endmodule

bind drv_fault_status drv_fault_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .srr_i       (srr_i),
    .ocs_en_i    (ocs_en_i),
    .old_en_i    (old_en_i),
    .sw_run_i    (sw_run_i),
    .oc_raw_i    (oc_raw_i),
    .ot_raw_i    (ot_raw_i),
    .fault_dis_o (fault_dis_o),
    .all_off_o   (all_off_o),
    .status_o    (status_o)
);

// File: tb/drv_fault_status_test.sv
`timescale 1ns/1ps
// Bench: a vector table for the status layout, then directed fault tests.
module drv_fault_status_test;
    localparam int UVD = 8;
    localparam int OCD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srr = 1'b0, ocs_en = 1'b1, old_en = 1'b0, run = 1'b1;
    logic [5:0]  on = '0, oc = '0, ot = '0, ol = '0;
    logic        pw = 1'b0, uv = 1'b0;
    logic [5:0]  dis;
    logic        aoff;
    logic [15:0] st;
    int          n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    drv_fault_status #(.UV_DLY(UVD), .OC_DLY(OCD)) uut (
        .clk(clk), .rst_n(rst_n), .srr_i(srr), .ocs_en_i(ocs_en),
        .old_en_i(old_en), .sw_run_i(run), .sw_on_i(on), .oc_raw_i(oc),
        .ot_raw_i(ot), .openload_i(ol), .prewarn_i(pw), .uv_raw_i(uv),
        .fault_dis_o(dis), .all_off_o(aoff), .status_o(st)
    );

    // Fields: on[30:25] old[24] ol[23:18] pw[17] run[16] expected status[15:0]
    localparam logic [30:0] VEC [0:6] = '{
        {6'b000001, 1'b0, 6'b000000, 1'b0, 1'b1, 16'h0002},  // R3 LS1
        {6'b100000, 1'b0, 6'b000000, 1'b1, 1'b1, 16'h0041},  // R3 HS3 + R2 prewarn
        {6'b101010, 1'b0, 6'b000000, 1'b0, 1'b1, 16'h0054},  // R3 high sides
        {6'b111111, 1'b0, 6'b000000, 1'b0, 1'b0, 16'h4000},  // R12 standby
        {6'b000000, 1'b1, 6'b010101, 1'b0, 1'b1, 16'h002A},  // R4 open-load
        {6'b111111, 1'b1, 6'b000000, 1'b1, 1'b1, 16'h0001},  // R4 on-bits hidden
        {6'b000000, 1'b1, 6'b100000, 1'b0, 1'b0, 16'h4040}   // R2 inhibit + R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_srr();
        srr = 1'b1;
        tick(1);
        srr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 status", st, 16'h0000);
        chk("R1 mask", dis, 6'h00);
        chk("R1 off", aoff, 1'b0);

        for (int k = 0; k < 7; k++) begin
            {on, old_en, ol, pw, run} = VEC[k][30:16];
            #1;
            chk("R2/R3/R4 vector", st, VEC[k][15:0]);
            tick(1);
        end
        on = '0; old_en = 1'b0; ol = '0; pw = 1'b0; run = 1'b1;

        // R7: overtemperature on LS2 (index 2, bit 3)
        on = 6'b000100;
        #1 chk("R3 LS2 on", st, 16'h0008);
        ot = 6'b000100;
        #1 chk("R7 before edge", dis, 6'h00);
        tick(1);
        chk("R7 mask", dis, 6'b000100);
        chk("R7 status", st, 16'h2000);
        // R8: reset ignored while hot, then honoured after recovery
        pulse_srr();
        chk("R8 still hot", dis, 6'b000100);
        ot = '0;
        tick(1);
        chk("R8 no reset yet", dis, 6'b000100);
        pulse_srr();
        chk("R11 mask cleared", dis, 6'h00);
        chk("R11 status", st, 16'h0008);

        // R9: overcurrent on LS1 with shutdown enabled
        on = 6'b000001; ocs_en = 1'b1; oc = 6'b000001;
        tick(OCD - 1);
        chk("R9 one short", dis, 6'h00);
        tick(1);
        chk("R9 trip mask", dis, 6'b000001);
        chk("R9 trip status", st, 16'h2000);
        oc = '0;
        pulse_srr();
        chk("R11 after oc", st, 16'h0002);
        oc = 6'b000001;
        tick(OCD - 1);
        oc = '0;
        tick(2);
        chk("R9 short pulse", dis, 6'h00);
        chk("R9 short status", st, 16'h0002);

        // R10: shutdown disabled
        ocs_en = 1'b0; oc = 6'b000001;
        tick(3 * OCD);
        chk("R10 mask", dis, 6'h00);
        chk("R10 status", st, 16'h0002);
        oc = '0; ocs_en = 1'b1;
        tick(1);

        // R5/R6: undervoltage
        uv = 1'b1;
        tick(UVD - 2);
        chk("R5 one short", aoff, 1'b0);
        tick(1);
        chk("R5 off", aoff, 1'b1);
        chk("R5 status", st, 16'h8000);
        tick(1);
        uv = 1'b0;
        #1 chk("R6 release", aoff, 1'b0);
        chk("R6 sticky", st, 16'h8002);
        tick(2);
        chk("R6 held", st, 16'h8002);
        pulse_srr();
        chk("R11 psf clear", st, 16'h0002);
        uv = 1'b1;
        tick(UVD - 2);
        uv = 1'b0;
        tick(1);
        uv = 1'b1;
        tick(UVD - 2);
        chk("R5 restart", aoff, 1'b0);
        chk("R5 restart status", st, 16'h0002);
        uv = 1'b0;
        tick(1);

        // R4: status-reset leaves open-load results alone
        old_en = 1'b1; ol = 6'b000011;
        #1 chk("R4 open-load", st, 16'h0006);
        pulse_srr();
        chk("R4 after reset", st, 16'h0006);
        old_en = 1'b0; ol = '0;

        // R12: standby
        run = 1'b0; on = 6'b111111;
        #1 chk("R12 off", aoff, 1'b1);
        chk("R12 status", st, 16'h4000);
        tick(2);
        chk("R12 no fault", dis, 6'h00);
        run = 1'b1;
        #1 chk("R3 all on", st, 16'h007E);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule